// File: doc/BRIEF.md
# Dual Latch-Reload Interval Timer Pair

This block holds two 16-bit down-counting interval timers. Software reaches them through an 8-bit register port and sees each timer one byte at a time. A prescaler pulse (`tick`) paces both counters. On each tick, each counter steps down by one. Timers that are not ticked hold their value.

Timer 1 reloads from its 16-bit latch. Starting from the latch value L, it counts L, L-1, ..., 0, 0xFFFF and then L again, so its period is L+2 ticks. Two bits from an auxiliary control register choose whether it raises its flag on every pass through zero (continuous mode) or only on the first pass after a load (one-shot mode). Timer 2 is always one-shot. It is loaded when its high byte is written. After reaching zero it wraps freely to 0xFFFF.

Each timer flag is set on the tick where its counter reaches zero. Specific register accesses clear the flags. The flags appear as single outputs and also at their fixed positions in an interrupt-flag byte, where a neighbouring interrupt controller decodes them.

Top module: `dual_interval_timer`

## Requirements
- R1: Reset leaves both Timer 1 latch bytes and the Timer 1 counter at 0xFFFF, the Timer 2 counter at 0x0000, and both flags clear.
- R2: Register reads are combinational and use these offsets:
  - 4: Timer 1 counter low byte
  - 5: Timer 1 counter high byte
  - 6: Timer 1 latch low byte
  - 7: Timer 1 latch high byte
  - 8: Timer 2 counter low byte
  - 9: Timer 2 counter high byte
  - Every other offset reads 0x00.
- R3: On each tick, the Timer 1 counter steps down by one. When the counter is 0xFFFF, a tick reloads it from the latch instead, so the period is latch+2 ticks. Without a tick the counter holds.
- R4: The Timer 1 flag is set on the tick where the counter becomes 0. With aux_mode = 2'b01 (continuous) it is set on every such tick. With any other aux_mode value it is set only on the first such tick after a load of the counter.
- R5: A write to offset 4 or 6 changes only the Timer 1 latch low byte. A write to offset 7 sets the latch high byte and clears the Timer 1 flag, leaving the counter unchanged.
- R6: A write to offset 5 sets the latch high byte and loads the counter from the full latch. It also clears the Timer 1 flag and re-arms one-shot mode. In that cycle it takes precedence over a tick.
- R7: A read of offset 4 clears the Timer 1 flag. A read of offset 5 leaves the flag unchanged. When a clearing access coincides with a flag-setting tick, the flag ends set.
- R8: A write to offset 8 holds a Timer 2 low byte. A write to offset 9 loads the Timer 2 counter with {written byte, held low byte}, clears the Timer 2 flag and arms it. Each tick steps the counter down by one, and 0x0000 wraps to 0xFFFF with no reload.
- R9: The Timer 2 flag is set on the first tick after a load where the counter becomes 0, and never again until the next load. A read of offset 8 clears it, unless a flag-setting tick coincides. A read of offset 9 leaves it unchanged.
- R10: irq_flags carries the Timer 1 flag at bit 6 and the Timer 2 flag at bit 5, with all other bits 0. t1_continuous is 1 exactly when aux_mode equals 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler enable; one count step per asserted cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives the read side effects) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| aux_mode | input | 2 | Timer 1 mode bits from the auxiliary control register |
| bus_rdata | output | 8 | Read data byte for bus_addr |
| irq_flags | output | 8 | Flag byte: Timer 1 at bit 6, Timer 2 at bit 5 |
| flag_t1 | output | 1 | Timer 1 flag |
| flag_t2 | output | 1 | Timer 2 flag |
| t1_continuous | output | 1 | Timer 1 is in continuous mode |

## Verification
Several directed runs use specific latch values and tick patterns:
- A small Timer 1 latch in continuous mode separates the latch+2 period from a latch+1 period.
- The same latch in one-shot mode shows whether a second pass through zero wrongly sets the flag again.
- A Timer 2 load followed by ticks past zero separates the free wrap from a reload.
- A read-clear issued on the very tick that sets a flag separates set-wins priority from clear-wins priority.

Constrained random traffic then mixes the following:
- tick densities
- mode changes
- high-byte values biased toward zero, so that counters actually expire
- reads and writes at every offset, including the unused ones

This traffic shows whether any access has a side effect beyond the ones listed.

// File: rtl/dit_pkg.sv
package dit_pkg;

  localparam int unsigned CNT_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned T1_FLAG_POS = 6;
  localparam int unsigned T2_FLAG_POS = 5;
  localparam logic [1:0]  T1_CONT_SEL = 2'b01;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t OFS_T1_CNT_LO = addr_t'(4);
  localparam addr_t OFS_T1_CNT_HI = addr_t'(5);
  localparam addr_t OFS_T1_LAT_LO = addr_t'(6);
  localparam addr_t OFS_T1_LAT_HI = addr_t'(7);
  localparam addr_t OFS_T2_LO     = addr_t'(8);
  localparam addr_t OFS_T2_HI     = addr_t'(9);

  typedef struct packed {
    logic t1_lat_lo_wr;
    logic t1_cnt_hi_wr;
    logic t1_lat_hi_wr;
    logic t1_lo_rd;
    logic t2_lo_wr;
    logic t2_hi_wr;
    logic t2_lo_rd;
  } strobe_t;

  // Timer 1 step: after the all-ones state the counter takes the latch.
  function automatic cnt_t reload_step(input cnt_t cur, input cnt_t lat);
    return (cur == '1) ? lat : cnt_t'(cur - cnt_t'(1));
  endfunction

  // Timer 2 step: plain modular decrement.
  function automatic cnt_t wrap_step(input cnt_t cur);
    return cnt_t'(cur - cnt_t'(1));
  endfunction

  function automatic byte_t lo_byte(input cnt_t v);
    return v[BYTE_W-1:0];
  endfunction

  function automatic byte_t hi_byte(input cnt_t v);
    return v[CNT_W-1:CNT_W-BYTE_W];
  endfunction

endpackage

// File: rtl/dit_regif.sv
module dit_regif
  import dit_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bus_wr,
  input  logic    bus_rd,
  input  addr_t   bus_addr,
  input  cnt_t    t1_cnt,
  input  cnt_t    t1_lat,
  input  cnt_t    t2_cnt,
  output strobe_t strb,
  output byte_t   rdata
);

  always_comb begin
    strb = '0;
    strb.t1_lat_lo_wr = bus_wr && (bus_addr == OFS_T1_CNT_LO || bus_addr == OFS_T1_LAT_LO);
    strb.t1_cnt_hi_wr = bus_wr && (bus_addr == OFS_T1_CNT_HI);
    strb.t1_lat_hi_wr = bus_wr && (bus_addr == OFS_T1_LAT_HI);
    strb.t1_lo_rd     = bus_rd && (bus_addr == OFS_T1_CNT_LO);
    strb.t2_lo_wr     = bus_wr && (bus_addr == OFS_T2_LO);
    strb.t2_hi_wr     = bus_wr && (bus_addr == OFS_T2_HI);
    strb.t2_lo_rd     = bus_rd && (bus_addr == OFS_T2_LO);
  end

  always_comb begin
    unique case (bus_addr)
      OFS_T1_CNT_LO: rdata = lo_byte(t1_cnt);
      OFS_T1_CNT_HI: rdata = hi_byte(t1_cnt);
      OFS_T1_LAT_LO: rdata = lo_byte(t1_lat);
      OFS_T1_LAT_HI: rdata = hi_byte(t1_lat);
      OFS_T2_LO:     rdata = lo_byte(t2_cnt);
      OFS_T2_HI:     rdata = hi_byte(t2_cnt);
      default:       rdata = '0;
    endcase
  end

  // R2: at most one write target is decoded per access
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.t1_lat_lo_wr, strb.t1_cnt_hi_wr, strb.t1_lat_hi_wr,
              strb.t2_lo_wr, strb.t2_hi_wr}));

endmodule

// File: rtl/dit_timer1.sv
module dit_timer1
  import dit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  cont_mode,
  input  logic  lat_lo_wr,
  input  logic  cnt_hi_wr,
  input  logic  lat_hi_wr,
  input  logic  lo_rd,
  input  byte_t wdata,
  output cnt_t  cnt,
  output cnt_t  lat,
  output logic  flag,
  output logic  zero_hit
);

  cnt_t next_cnt;
  logic armed;
  logic set_evt;
  logic clr_evt;

  assign next_cnt = reload_step(cnt, lat);
  assign zero_hit = tick && !cnt_hi_wr && (next_cnt == '0);
  assign set_evt  = zero_hit && (cont_mode || armed);
  assign clr_evt  = lat_hi_wr || lo_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat   <= '1;
      cnt   <= '1;
      flag  <= 1'b0;
      armed <= 1'b1;
    end else if (cnt_hi_wr) begin
      lat[CNT_W-1:CNT_W-BYTE_W] <= wdata;
      cnt   <= {wdata, lo_byte(lat)};
      flag  <= 1'b0;
      armed <= 1'b1;
    end else begin
      if (lat_lo_wr) lat[BYTE_W-1:0] <= wdata;
      if (lat_hi_wr) lat[CNT_W-1:CNT_W-BYTE_W] <= wdata;
      if (tick) cnt <= next_cnt;
      if (zero_hit) armed <= 1'b0;
      if (set_evt) flag <= 1'b1;
      else if (clr_evt) flag <= 1'b0;
    end
  end

  // R3: a tick from the all-ones state reloads the previous latch value
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_hi_wr && cnt == '1) |=> (cnt == $past(lat)));

  // R3: without a tick or a load the counter holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_hi_wr) |=> $stable(cnt));

  // R6: a counter-high write leaves counter equal to latch with flag clear
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hi_wr |=> (cnt == lat && !flag));

  // R4: in continuous mode every zero crossing sets the flag
  assert_cont_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_hit && cont_mode) |=> flag);

endmodule

// File: rtl/dit_timer2.sv
module dit_timer2
  import dit_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  lo_wr,
  input  logic  hi_wr,
  input  logic  lo_rd,
  input  byte_t wdata,
  output cnt_t  cnt,
  output logic  flag,
  output logic  zero_hit
);

  byte_t lo_hold;
  logic  armed;

  assign zero_hit = tick && !hi_wr && (wrap_step(cnt) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_hold <= '1;
      cnt     <= '0;
      flag    <= 1'b0;
      armed   <= 1'b0;
    end else if (hi_wr) begin
      cnt   <= {wdata, lo_hold};
      flag  <= 1'b0;
      armed <= 1'b1;
    end else begin
      if (lo_wr) lo_hold <= wdata;
      if (tick) cnt <= wrap_step(cnt);
      if (zero_hit) armed <= 1'b0;
      if (zero_hit && armed) flag <= 1'b1;
      else if (lo_rd) flag <= 1'b0;
    end
  end

  // R8: zero wraps to all ones, no reload
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hi_wr && cnt == '0) |=> (cnt == '1));

  // R8: a high-byte write clears the flag
  assert_load_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> !flag);

  // R9: once disarmed, a clear flag stays clear until the next load
  assert_single_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !hi_wr && !flag) |=> !flag);

endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic [1:0] aux_mode,
  output logic [7:0] bus_rdata,
  output logic [7:0] irq_flags,
  output logic       flag_t1,
  output logic       flag_t2,
  output logic       t1_continuous
);

  strobe_t strb;
  cnt_t    t1_cnt, t1_lat, t2_cnt;
  logic    t1_zero_hit, t2_zero_hit;

  assign t1_continuous = (aux_mode == T1_CONT_SEL);

  dit_regif u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .t1_cnt   (t1_cnt),
    .t1_lat   (t1_lat),
    .t2_cnt   (t2_cnt),
    .strb     (strb),
    .rdata    (bus_rdata)
  );

  dit_timer1 u_t1 (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cont_mode (t1_continuous),
    .lat_lo_wr (strb.t1_lat_lo_wr),
    .cnt_hi_wr (strb.t1_cnt_hi_wr),
    .lat_hi_wr (strb.t1_lat_hi_wr),
    .lo_rd     (strb.t1_lo_rd),
    .wdata     (bus_wdata),
    .cnt       (t1_cnt),
    .lat       (t1_lat),
    .flag      (flag_t1),
    .zero_hit  (t1_zero_hit)
  );

  dit_timer2 u_t2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .lo_wr    (strb.t2_lo_wr),
    .hi_wr    (strb.t2_hi_wr),
    .lo_rd    (strb.t2_lo_rd),
    .wdata    (bus_wdata),
    .cnt      (t2_cnt),
    .flag     (flag_t2),
    .zero_hit (t2_zero_hit)
  );

  always_comb begin
    irq_flags = '0;
    irq_flags[T1_FLAG_POS] = flag_t1;
    irq_flags[T2_FLAG_POS] = flag_t2;
  end

  // R9: an armed Timer 2 zero crossing shows up in the flag byte
  assert_t2_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_zero_hit && !$past(t2_zero_hit) && $past(bus_wr) && $past(bus_addr) == OFS_T2_HI)
      |=> irq_flags[T2_FLAG_POS]);

  // R10: a Timer 1 zero crossing in continuous mode shows up at bit 6
  assert_t1_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_zero_hit && t1_continuous) |=> irq_flags[T1_FLAG_POS]);

endmodule

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] aux_mode = '0;
  logic [7:0] bus_rdata, irq_flags;
  logic       flag_t1, flag_t2, t1_continuous;

  int n_checks = 0;
  int n_fail   = 0;

  // reference state
  logic [15:0] m_lat1, m_cnt1, m_cnt2;
  logic [7:0]  m_lo2;
  logic        m_arm1, m_f1, m_arm2, m_f2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .aux_mode(aux_mode),
    .bus_rdata(bus_rdata), .irq_flags(irq_flags), .flag_t1(flag_t1),
    .flag_t2(flag_t2), .t1_continuous(t1_continuous)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'd4: return m_cnt1[7:0];
      4'd5: return m_cnt1[15:8];
      4'd6: return m_lat1[7:0];
      4'd7: return m_lat1[15:8];
      4'd8: return m_cnt2[7:0];
      4'd9: return m_cnt2[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [3:0] a);
    if (a == 4'd4 || a == 4'd5) return "R3";
    if (a == 4'd6 || a == 4'd7) return "R5";
    if (a == 4'd8 || a == 4'd9) return "R8";
    return "R2";
  endfunction

  function automatic logic [7:0] exp_flag_byte();
    logic [7:0] v;
    v = 8'h00;
    if (m_f1) v = v | 8'h40;
    if (m_f2) v = v | 8'h20;
    return v;
  endfunction

  task automatic model_step(input bit tk, input bit w, input bit r,
                            input logic [3:0] a, input logic [7:0] d);
    logic [15:0] after1;
    bit load1, hit1, won1, load2, hit2;
    after1 = (m_cnt1 == 16'hFFFF) ? m_lat1 : m_cnt1 - 16'd1;
    load1  = w && a == 4'd5;
    hit1   = tk && !load1 && after1 == 16'h0000;
    won1   = hit1 && (aux_mode == 2'b01 || m_arm1);
    load2  = w && a == 4'd9;
    hit2   = tk && !load2 && m_cnt2 == 16'h0001;
    if (load1) begin
      m_lat1 = {d, m_lat1[7:0]};
      m_cnt1 = m_lat1;
      m_arm1 = 1'b1;
      m_f1   = 1'b0;
    end else begin
      if (tk) m_cnt1 = after1;
      if (w && (a == 4'd4 || a == 4'd6)) m_lat1[7:0] = d;
      if (w && a == 4'd7) m_lat1[15:8] = d;
      if (hit1) m_arm1 = 1'b0;
      if (won1) m_f1 = 1'b1;
      else if ((w && a == 4'd7) || (r && a == 4'd4)) m_f1 = 1'b0;
    end
    if (load2) begin
      m_cnt2 = {d, m_lo2};
      m_arm2 = 1'b1;
      m_f2   = 1'b0;
    end else begin
      if (tk) m_cnt2 = m_cnt2 - 16'd1;
      if (w && a == 4'd8) m_lo2 = d;
      if (hit2 && m_arm2) m_f2 = 1'b1;
      else if (r && a == 4'd8) m_f2 = 1'b0;
      if (hit2) m_arm2 = 1'b0;
    end
  endtask

  task automatic cyc(input bit tk, input bit w, input bit r,
                     input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = tk; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    #1;
    if (r) chk(read_tag(a), bus_rdata, exp_read(a));
    chk("R10", t1_continuous, aux_mode == 2'b01);
    @(posedge clk);
    model_step(tk, w, r, a, d);
    #2;
    tick = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R4", flag_t1, m_f1);
    chk("R9", flag_t2, m_f2);
    chk("R10", irq_flags, exp_flag_byte());
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 4'd0, 8'h00);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240607));
    m_lat1 = 16'hFFFF; m_cnt1 = 16'hFFFF; m_cnt2 = 16'h0000; m_lo2 = 8'hFF;
    m_arm1 = 1'b1; m_f1 = 1'b0; m_arm2 = 1'b0; m_f2 = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values seen through the register port
    cyc(0, 0, 1, 4'd4, 0); chk("R1", bus_rdata, 8'hFF);
    cyc(0, 0, 1, 4'd7, 0); chk("R1", bus_rdata, 8'hFF);
    cyc(0, 0, 1, 4'd9, 0); chk("R1", bus_rdata, 8'h00);
    chk("R1", irq_flags, 8'h00);
    cyc(0, 0, 1, 4'd3, 0); chk("R2", bus_rdata, 8'h00);

    // continuous mode, latch 3 -> period 5
    aux_mode = 2'b01;
    cyc(0, 1, 0, 4'd6, 8'h03);
    cyc(0, 1, 0, 4'd7, 8'h00);
    cyc(0, 0, 1, 4'd5, 0); chk("R5", bus_rdata, 8'hFF);
    cyc(0, 1, 0, 4'd5, 8'h00);
    cyc(0, 0, 1, 4'd4, 0); chk("R6", bus_rdata, 8'h03);
    ticks(3); chk("R4", flag_t1, 1'b1);
    cyc(0, 0, 1, 4'd5, 0); chk("R7", flag_t1, 1'b1);
    cyc(0, 0, 1, 4'd4, 0); chk("R7", flag_t1, 1'b0);
    ticks(4); chk("R3", flag_t1, 1'b0);
    ticks(1); chk("R3", flag_t1, 1'b1);

    // one-shot mode
    aux_mode = 2'b00;
    cyc(0, 1, 0, 4'd5, 8'h00); chk("R6", flag_t1, 1'b0);
    ticks(3); chk("R4", flag_t1, 1'b1);
    cyc(0, 0, 1, 4'd4, 0); chk("R7", flag_t1, 1'b0);
    ticks(7); chk("R4", flag_t1, 1'b0);
    // read-clear on the setting tick: set wins
    cyc(0, 1, 0, 4'd5, 8'h00);
    ticks(2);
    cyc(1, 0, 1, 4'd4, 0); chk("R7", flag_t1, 1'b1);

    // Timer 2
    cyc(0, 1, 0, 4'd8, 8'h02);
    cyc(0, 1, 0, 4'd9, 8'h00);
    ticks(2); chk("R9", flag_t2, 1'b1);
    ticks(1);
    cyc(0, 0, 1, 4'd9, 0); chk("R8", bus_rdata, 8'hFF); chk("R9", flag_t2, 1'b1);
    cyc(0, 0, 1, 4'd8, 0); chk("R9", flag_t2, 1'b0);

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      bit tk, w, r;
      logic [3:0] a;
      logic [7:0] d;
      int op;
      if ($urandom_range(0, 99) < 2) aux_mode = 2'($urandom_range(0, 3));
      tk = ($urandom_range(0, 3) != 0);
      op = $urandom_range(0, 9);
      w = (op < 2);
      r = (op >= 2 && op < 5);
      a = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 3) != 0) a = 4'($urandom_range(4, 9));
      d = 8'($urandom);
      if (w && (a == 4'd5 || a == 4'd7 || a == 4'd9) && $urandom_range(0, 3) != 0) d = 8'h00;
      if (w && (a == 4'd4 || a == 4'd6 || a == 4'd8)) d = 8'($urandom_range(0, 12));
      cyc(tk, w, r, a, d);
    end

    finish_run();
  end

endmodule